// File: doc/BRIEF.md
# Dual-Width Parallel Host Bus Interface

This block sits between a host processor bus and the command and data logic of a display controller. The host moves bytes over a parallel bus that is either eight lines wide or four lines wide, using one of two strobe styles. The first style has separate active-low write and read strobes. The second style has one read/write level and one active-high enable. A pair of chip selects gates all activity. A command/data pin tags each byte as control traffic or display data.

Completed write bytes leave the block as a one-cycle valid pulse, together with the byte and its command/data flag. Reads are served from a byte that the read side holds ready. A one-cycle request pulse tells that read side to advance to the next byte. In four-line mode every byte, dummy reads included, is carried as two nibble transfers with the high nibble first. The nibble phase is resynchronised whenever the command/data pin toggles or the chip is deselected. All strobe inputs are sampled by the block clock and treated as already synchronised.

Top module: `hbus_host_if`

## Requirements
- R1: In eight-line mode, each completed write transfer raises `wr_valid` for exactly one cycle, in the cycle after the strobe edge is sampled, with `wr_byte` equal to `din`.
- R2: When `proto_68` is 0, `strb_a` is an active-low write strobe and `strb_b` is an active-low read strobe. A write is captured on the rising edge of `strb_a`, and a read starts on the falling edge of `strb_b`.
- R3: When `proto_68` is 1, `strb_a` is the read/write level (1 means read) and `strb_b` is an active-high enable. A write is captured on the falling edge of `strb_b` while `strb_a` is 0, and a read starts on the rising edge of `strb_b` while `strb_a` is 1.
- R4: When `narrow` is 1, nibbles travel on `din[3:0]`. The first write transfer supplies the high nibble and the second supplies the low nibble. `wr_valid` pulses only after the second transfer.
- R5: In eight-line mode, a read presents the value of `rd_byte` on `dout` and raises `rd_req` for one cycle.
- R6: In four-line mode, the first read transfer latches `rd_byte`, puts its high nibble on `dout[3:0]` and raises `rd_req`. The second read transfer puts the latched low nibble on `dout[3:0]` without `rd_req`. `dout[7:4]` is 0 in both transfers, and dummy reads follow the same two steps.
- R7: A change of `cd` while the chip is selected returns the nibble phase to the high nibble. Any pending high nibble is discarded.
- R8: The chip is selected only when `cs_n` is 0 and `cs_hi` is 1. While it is deselected, strobes produce neither `wr_valid` nor `rd_req`, `dout` keeps its value, and the nibble phase returns to the high nibble.
- R9: After reset, `wr_valid`, `rd_req` and `dout` are 0, and the next nibble is the high nibble.
- R10: `wr_cd` carries the level of `cd` at the final transfer of the byte. A level of 0 marks control traffic and 1 marks display data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| cd | input | 1 | Command/data tag: 0 control, 1 data |
| narrow | input | 1 | 1 selects the four-line nibble bus |
| proto_68 | input | 1 | 0 selects separate strobes, 1 selects read/write plus enable |
| strb_a | input | 1 | Write strobe, or read/write level |
| strb_b | input | 1 | Read strobe, or enable |
| din | input | 8 | Host write lines |
| rd_byte | input | 8 | Byte held ready by the read side |
| wr_valid | output | 1 | One-cycle pulse for a completed write byte |
| wr_byte | output | 8 | Assembled write byte |
| wr_cd | output | 1 | Command/data tag of the write byte |
| rd_req | output | 1 | One-cycle request to advance the read byte |
| dout | output | 8 | Read data driven toward the host |

## Verification
Both strobe styles are exercised at both bus widths, using byte values whose high and low nibbles differ. A swapped or lost nibble therefore shows up in the assembled byte. Reads are checked against a source that changes after every request, which separates a properly held low nibble from a freshly fetched one. Three patterns target the phase rules: an orphan high nibble followed by a toggle of the command/data pin, a deselect in the middle of a byte, and strobes issued while either chip select is inactive.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic {
        PROTO_SPLIT  = 1'b0,
        PROTO_ENABLE = 1'b1
    } proto_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
        logic resync;
    } bus_evt_t;

endpackage

// File: rtl/hbus_strobe_decode.sv
module hbus_strobe_decode
    import hbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     cs_hi,
    input  logic     cd,
    input  logic     proto_68,
    input  logic     strb_a,
    input  logic     strb_b,
    output bus_evt_t evt
);

    typedef struct packed {
        logic armed;
        logic sa;
        logic sb;
        logic cd;
    } dec_state_t;

    dec_state_t state_d, state_q;

    logic   a_rise, b_fall, b_rise;
    logic   wr_raw, rd_raw, live;
    proto_e proto;

    always_comb begin
        proto         = proto_e'(proto_68);
        state_d.armed = 1'b1;
        state_d.sa    = strb_a;
        state_d.sb    = strb_b;
        state_d.cd    = cd;

        a_rise = !state_q.sa && strb_a;
        b_fall = state_q.sb && !strb_b;
        b_rise = !state_q.sb && strb_b;

        case (proto)
            PROTO_SPLIT: begin
                wr_raw = a_rise;
                rd_raw = b_fall;
            end
            default: begin
                wr_raw = b_fall && !strb_a;
                rd_raw = b_rise && strb_a;
            end
        endcase

        live       = !cs_n && cs_hi && state_q.armed;
        evt.sel    = !cs_n && cs_hi;
        evt.wr     = live && wr_raw;
        evt.rd     = live && rd_raw && !wr_raw;
        evt.resync = live && (cd != state_q.cd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{armed: 1'b0, sa: 1'b1, sb: 1'b1, cd: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    // R2
    split_wr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.wr && !proto_68) |-> (strb_a && !state_q.sa));

    // R3
    enable_rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.rd && proto_68) |-> (strb_a && strb_b && !state_q.sb));

endmodule

// File: rtl/hbus_nibble_seq.sv
module hbus_nibble_seq
    import hbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              narrow,
    input  logic              cd,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_cd,
    output logic              rd_req,
    output logic [DATA_W-1:0] dout
);

    localparam int NIB_W = DATA_W / 2;

    typedef struct packed {
        phase_e            phase;
        logic [NIB_W-1:0]  hi_nib;
        logic [NIB_W-1:0]  rd_low;
        logic              wr_valid;
        logic [DATA_W-1:0] wr_byte;
        logic              wr_cd;
        logic              rd_req;
        logic [DATA_W-1:0] dout;
    } seq_state_t;

    seq_state_t state_d, state_q;
    phase_e     ph;

    always_comb begin
        state_d          = state_q;
        state_d.wr_valid = 1'b0;
        state_d.rd_req   = 1'b0;

        ph = state_q.phase;
        if (!evt.sel || !narrow || evt.resync) begin
            ph = PH_HIGH;
        end
        state_d.phase = ph;

        if (evt.wr) begin
            if (!narrow) begin
                state_d.wr_valid = 1'b1;
                state_d.wr_byte  = din;
                state_d.wr_cd    = cd;
            end else if (ph == PH_HIGH) begin
                state_d.hi_nib = din[NIB_W-1:0];
                state_d.phase  = PH_LOW;
            end else begin
                state_d.wr_valid = 1'b1;
                state_d.wr_byte  = {state_q.hi_nib, din[NIB_W-1:0]};
                state_d.wr_cd    = cd;
                state_d.phase    = PH_HIGH;
            end
        end else if (evt.rd) begin
            if (!narrow) begin
                state_d.rd_req = 1'b1;
                state_d.dout   = rd_byte;
            end else if (ph == PH_HIGH) begin
                state_d.rd_req = 1'b1;
                state_d.rd_low = rd_byte[NIB_W-1:0];
                state_d.dout   = {{(DATA_W-NIB_W){1'b0}}, rd_byte[DATA_W-1:NIB_W]};
                state_d.phase  = PH_LOW;
            end else begin
                state_d.dout  = {{(DATA_W-NIB_W){1'b0}}, state_q.rd_low};
                state_d.phase = PH_HIGH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_HIGH, default: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_valid = state_q.wr_valid;
    assign wr_byte  = state_q.wr_byte;
    assign wr_cd    = state_q.wr_cd;
    assign rd_req   = state_q.rd_req;
    assign dout     = state_q.dout;

    // R1
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.wr_valid |=> !state_q.wr_valid);

    // R5
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rd_req |=> !state_q.rd_req);

    // R4
    first_nibble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && evt.wr && !evt.resync && state_q.phase == PH_HIGH)
            |=> (!state_q.wr_valid && state_q.phase == PH_LOW));

    // R6
    narrow_rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && evt.rd) |=> (state_q.dout[DATA_W-1:NIB_W] == '0));

    // R7
    resync_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.resync && !evt.wr && !evt.rd) |=> (state_q.phase == PH_HIGH));

    // R8
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.sel |=> (state_q.phase == PH_HIGH && !state_q.wr_valid && !state_q.rd_req));

endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
    import hbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cs_hi,
    input  logic              cd,
    input  logic              narrow,
    input  logic              proto_68,
    input  logic              strb_a,
    input  logic              strb_b,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_cd,
    output logic              rd_req,
    output logic [DATA_W-1:0] dout
);

    bus_evt_t evt;

    hbus_strobe_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .cs_hi    (cs_hi),
        .cd       (cd),
        .proto_68 (proto_68),
        .strb_a   (strb_a),
        .strb_b   (strb_b),
        .evt      (evt)
    );

    hbus_nibble_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .narrow   (narrow),
        .cd       (cd),
        .din      (din),
        .rd_byte  (rd_byte),
        .wr_valid (wr_valid),
        .wr_byte  (wr_byte),
        .wr_cd    (wr_cd),
        .rd_req   (rd_req),
        .dout     (dout)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wr_valid && !rd_req));

endmodule

// File: tb/hbus_host_if_tb.sv
module hbus_host_if_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0, cs_hi = 1'b1, cd = 1'b0;
    logic       narrow = 1'b0, proto_68 = 1'b0;
    logic       strb_a = 1'b1, strb_b = 1'b1;
    logic [7:0] din = '0, rd_src = 8'h5A;
    logic       wr_valid, wr_cd, rd_req;
    logic [7:0] wr_byte, dout;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    hbus_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .cd(cd),
        .narrow(narrow), .proto_68(proto_68), .strb_a(strb_a), .strb_b(strb_b),
        .din(din), .rd_byte(rd_src), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .wr_cd(wr_cd), .rd_req(rd_req), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for write bytes; read source advances on each request
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected write", {7'd0, wr_cd, wr_byte}, 16'h0);
            end else begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({wr_cd, wr_byte} == e, t, {7'd0, wr_cd, wr_byte}, {7'd0, e});
            end
        end
        if (rst_n && rd_req) rd_src = rd_src + 8'h3B;
    end

    task automatic expect_wr(input logic c, input logic [7:0] b, input string t);
        exp_q.push_back({c, b});
        tag_q.push_back(t);
    endtask

    task automatic do_reset(input logic p68, input logic nar);
        @(negedge clk);
        rst_n = 1'b0; proto_68 = p68; narrow = nar;
        strb_a = 1'b1; strb_b = p68 ? 1'b0 : 1'b1;
        cs_n = 1'b0; cs_hi = 1'b1; cd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_xfer(input logic c, input logic [7:0] d, output logic seen_valid);
        @(negedge clk);
        cd = c; din = d;
        if (proto_68) begin strb_a = 1'b0; strb_b = 1'b1; end
        else strb_a = 1'b0;
        @(negedge clk);
        if (proto_68) strb_b = 1'b0; else strb_a = 1'b1;
        @(negedge clk);
        seen_valid = wr_valid;
        if (proto_68) strb_a = 1'b1;
    endtask

    task automatic rd_xfer(input logic c, output logic [7:0] seen, output logic req);
        @(negedge clk);
        cd = c;
        if (proto_68) begin strb_a = 1'b1; strb_b = 1'b1; end
        else strb_b = 1'b0;
        @(negedge clk);
        seen = dout; req = rd_req;
        if (proto_68) strb_b = 1'b0; else strb_b = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_byte(input logic c, input logic [7:0] b, input string t);
        logic v;
        expect_wr(c, b, t);
        if (narrow) begin
            wr_xfer(c, {4'h0, b[7:4]}, v);
            check(v == 1'b0, "R4 no pulse after first nibble", {15'd0, v}, 16'h0);
            wr_xfer(c, {4'h0, b[3:0]}, v);
        end else begin
            wr_xfer(c, b, v);
        end
    endtask

    task automatic wide_read(input string t);
        logic [7:0] e, s;
        logic       q;
        e = rd_src;
        rd_xfer(1'b1, s, q);
        check(s == e, t, {8'd0, s}, {8'd0, e});
        check(q == 1'b1, "R5 rd_req pulse", {15'd0, q}, 16'h1);
    endtask

    task automatic narrow_read(input string t);
        logic [7:0] e, s;
        logic       q;
        e = rd_src;
        rd_xfer(1'b1, s, q);
        check(s == {4'h0, e[7:4]}, t, {8'd0, s}, {12'd0, e[7:4]});
        check(q == 1'b1, "R6 request on first nibble", {15'd0, q}, 16'h1);
        rd_xfer(1'b1, s, q);
        check(s == {4'h0, e[3:0]}, t, {8'd0, s}, {12'd0, e[3:0]});
        check(q == 1'b0, "R6 no request on second nibble", {15'd0, q}, 16'h0);
    endtask

    initial begin
        logic       v, q;
        logic [7:0] s, hold;

        do_reset(1'b0, 1'b0);
        // R9
        check(wr_valid == 1'b0, "R9 wr_valid after reset", {15'd0, wr_valid}, 16'h0);
        check(rd_req == 1'b0, "R9 rd_req after reset", {15'd0, rd_req}, 16'h0);
        check(dout == 8'h00, "R9 dout after reset", {8'd0, dout}, 16'h0);

        // split strobes, eight lines: R1 R2 R10
        write_byte(1'b0, 8'hA5, "R1 R2 R10 command byte");
        write_byte(1'b1, 8'h3C, "R1 R2 R10 data byte");
        wide_read("R5 R2 read byte");

        // R8 deselect by either select
        cs_n = 1'b1;
        wr_xfer(1'b1, 8'hEE, v);
        check(v == 1'b0, "R8 write ignored with cs_n high", {15'd0, v}, 16'h0);
        cs_n = 1'b0; cs_hi = 1'b0;
        hold = dout;
        rd_xfer(1'b1, s, q);
        check(q == 1'b0 && s == hold, "R8 read ignored with cs_hi low", {7'd0, q, s}, {8'd0, hold});
        cs_hi = 1'b1;

        // split strobes, four lines: R4 R6
        do_reset(1'b0, 1'b1);
        write_byte(1'b1, 8'h9E, "R4 narrow write");
        narrow_read("R6 narrow read");
        narrow_read("R6 dummy read pair");

        // R7 orphan nibble dropped on cd toggle
        wr_xfer(1'b1, 8'h07, v);
        expect_wr(1'b0, 8'h2D, "R7 resync after cd change");
        wr_xfer(1'b0, 8'h02, v);
        check(v == 1'b0, "R7 first nibble after resync", {15'd0, v}, 16'h0);
        wr_xfer(1'b0, 8'h0D, v);

        // R8 deselect mid byte
        wr_xfer(1'b0, 8'h04, v);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        write_byte(1'b0, 8'hB1, "R8 phase reset by deselect");

        // enable style, eight lines: R3
        do_reset(1'b1, 1'b0);
        write_byte(1'b0, 8'h61, "R3 R10 enable style command");
        write_byte(1'b1, 8'hF0, "R3 R10 enable style data");
        wide_read("R3 R5 enable style read");

        // enable style, four lines
        do_reset(1'b1, 1'b1);
        write_byte(1'b1, 8'hC7, "R3 R4 enable style narrow write");
        narrow_read("R3 R6 enable style narrow read");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all expected writes seen", exp_q.size(), 16'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule